// File: doc/BRIEF.md
# Descending Interruptible Block-Copy Engine

This block copies a run of 16-bit words from a source region to a destination region of a word-addressed memory. A request gives two 32-bit word base addresses, each as a high and a low 16-bit half, and a tagged 16-bit word count. The engine moves one word at a time. Each move is a read followed by a write. It starts at the highest offset and works down to offset zero.

The work is split into chunks of sixteen words. The first chunk takes the odd remainder of the count and every later chunk is a full sixteen. Before a chunk writes anything, the engine reads the first and last source words and the first and last destination words of that chunk. An access fault therefore surfaces before that chunk changes memory. An interrupt request is looked at only where one chunk ends and another would begin. If it is set there, the engine stops. The remaining index it exposes tells software how many words are still to go. Issuing the request again with that index plus one as the count, and the same bases, finishes the copy.

Top module: `desc_blk_copy`

## Requirements
- R1: Word i of the block (offset i from each base) is copied by a read of source+i, then in the next cycle a write of that read's data to destination+i. Offsets are visited strictly from count-1 down to 0.
- R2: Chunk boundaries fall where the remaining index has its low four bits all zero. The first chunk therefore moves ((count-1) mod 16)+1 words and each later chunk moves 16.
- R3: Before the moves of each chunk, four reads are issued in this order: source top, source bottom, destination top, destination bottom. Top is the chunk's highest offset and bottom is its lowest.
- R4: A fault returned with any of the four probe reads ends the run with trap code 3. The fault arrives in the cycle after the read. No further memory request and no write of that chunk follows. The remaining index keeps the value it had when that chunk began.
- R5: An accepted count of zero gives a done pulse in the next cycle. It makes no memory request and sets the remaining index to 16'hFFFF.
- R6: A count whose tag word differs from the small-integer tag (parameter, default 16'h000E) gives trap code 1 in the next cycle. There is no memory request and the remaining index is unchanged.
- R7: A correctly tagged count above 32768 gives trap code 2 in the next cycle, with no memory request. A count of exactly 32768 is accepted.
- R8: The remaining index equals (words still to copy) - 1. It drops by one with each write and reads 16'hFFFF after normal completion and after reset.
- R9: The interrupt input is sampled only at the end of a chunk when more words remain. If it is set, the engine gives an intr pulse and leaves the remaining index at a value whose low four bits are 1111. If it is set during the final chunk, the run still ends with done.
- R10: done, intr and trap valid are single-cycle pulses and never coincide. A start while busy is ignored.
- R11: Offsets are added to the full 32-bit base, so a carry out of the low half propagates into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, honoured only when idle |
| srcHi | input | 16 | Source base, upper half |
| srcLo | input | 16 | Source base, lower half |
| dstHi | input | 16 | Destination base, upper half |
| dstLo | input | 16 | Destination base, lower half |
| cntTag | input | 16 | Type tag accompanying the count |
| cntVal | input | 16 | Number of words to copy |
| irq | input | 1 | Interrupt request, sampled at chunk ends |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | Normal completion pulse |
| intr | output | 1 | Stopped-for-interrupt pulse |
| trapValid | output | 1 | Trap pulse |
| trapCode | output | 2 | Trap reason: 1 tag, 2 range, 3 fault |
| remIdx | output | 16 | Remaining index (words left minus one) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, one cycle after the read |
| memFault | input | 1 | Fault flag for the read of the previous cycle |

## Verification
The bench predicts the full memory request stream: probes, reads and writes with their data. It compares every request in turn, so a wrong chunk length, a wrong probe order, or an ascending walk shows up as the first mismatched address. Counts of 5, 16, 37 and 40 cover a short first chunk, an exact chunk and several chunks. A base just below a 64K boundary catches a missing carry into the high half.

Faults are injected on a later chunk's destination top and on a first chunk's source bottom. An engine that wrote before probing, kept issuing reads, or changed the index would emit extra requests or a wrong index. The interrupt is checked three ways: it stops a multi-chunk copy at a boundary; a resume with the reported index finishes the rest; and it has no effect on a copy that fits in one chunk.

The count screens are covered with a zero count, a bad tag, 40000, and 32768 under interrupt. Getting any of them wrong leaves a request where none is expected or gives the wrong pulse.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_TAG   = 2'd1,
    TRAP_RANGE = 2'd2,
    TRAP_FAULT = 2'd3
  } trapCode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_READ,
    ST_WRITE
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBases;
    logic loadRem;
    logic fillRem;
    logic decRem;
    logic pickDst;
    logic pickBottom;
  } ctlStrobe_t;

endpackage

// File: rtl/blkcopy_dp.sv
module blkcopy_dp
  import blkcopy_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HALF_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int CHUNK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [HALF_W-1:0] srcHi,
  input  logic [HALF_W-1:0] srcLo,
  input  logic [HALF_W-1:0] dstHi,
  input  logic [HALF_W-1:0] dstLo,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [CNT_W-1:0]  remIdx,
  output logic              atChunkBottom,
  output logic              remIsZero
);

  localparam int PAD_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] srcBase;
  logic [ADDR_W-1:0] dstBase;
  logic [CNT_W-1:0]  chunkFloor;
  logic [CNT_W-1:0]  offset;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase <= '0;
      dstBase <= '0;
      remIdx  <= '1;
    end else begin
      if (strobe.loadBases) begin
        srcBase <= {srcHi, srcLo};
        dstBase <= {dstHi, dstLo};
      end
      if (strobe.loadRem)      remIdx <= cntVal - 1'b1;
      else if (strobe.fillRem) remIdx <= '1;
      else if (strobe.decRem)  remIdx <= remIdx - 1'b1;
    end
  end

  assign chunkFloor    = {remIdx[CNT_W-1:CHUNK_LOG2], {CHUNK_LOG2{1'b0}}};
  assign atChunkBottom = (remIdx[CHUNK_LOG2-1:0] == '0);
  assign remIsZero     = (remIdx == '0);

  assign offset  = strobe.pickBottom ? chunkFloor : remIdx;
  assign base    = strobe.pickDst ? dstBase : srcBase;
  assign memAddr = base + {{PAD_W{1'b0}}, offset};

  // read data goes straight to the write of the following cycle
  assign memWdata = memRdata;

endmodule

// File: rtl/blkcopy_ctl.sv
module blkcopy_ctl
  import blkcopy_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          TAG_W     = 16,
  parameter logic [15:0] SMALL_TAG = 16'h000E,
  parameter int          MAX_COUNT = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TAG_W-1:0] cntTag,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             irq,
  input  logic             memFault,
  input  logic             atChunkBottom,
  input  logic             remIsZero,
  output ctlStrobe_t       strobe,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             done,
  output logic             intr,
  output logic             trapValid,
  output logic [1:0]       trapCode
);

  localparam int PROBES = 4;
  localparam int PC_W   = $clog2(PROBES + 1);

  engState_e       state;
  logic [PC_W-1:0] probeCnt;
  logic            tagBad;
  logic            rangeBad;
  logic            cntZero;
  logic            faultNow;
  logic            probeIssue;

  assign tagBad     = (cntTag != SMALL_TAG[TAG_W-1:0]);
  assign rangeBad   = (cntVal > CNT_W'(MAX_COUNT));
  assign cntZero    = (cntVal == '0);
  assign faultNow   = (probeCnt != '0) && memFault;
  assign probeIssue = (probeCnt < PC_W'(PROBES)) && !faultNow;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start && !tagBad && !rangeBad) begin
          if (cntZero) strobe.fillRem = 1'b1;
          else begin
            strobe.loadBases = 1'b1;
            strobe.loadRem   = 1'b1;
          end
        end
      end
      ST_PROBE: begin
        memReq            = probeIssue;
        strobe.pickDst    = probeCnt[1];
        strobe.pickBottom = probeCnt[0];
      end
      ST_READ: begin
        memReq = 1'b1;
      end
      ST_WRITE: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        strobe.pickDst = 1'b1;
        strobe.decRem  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      probeCnt  <= '0;
      done      <= 1'b0;
      intr      <= 1'b0;
      trapValid <= 1'b0;
      trapCode  <= TRAP_NONE;
    end else begin
      done      <= 1'b0;
      intr      <= 1'b0;
      trapValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (tagBad) begin
              trapValid <= 1'b1;
              trapCode  <= TRAP_TAG;
            end else if (rangeBad) begin
              trapValid <= 1'b1;
              trapCode  <= TRAP_RANGE;
            end else if (cntZero) begin
              done <= 1'b1;
            end else begin
              state    <= ST_PROBE;
              probeCnt <= '0;
            end
          end
        end
        ST_PROBE: begin
          if (faultNow) begin
            trapValid <= 1'b1;
            trapCode  <= TRAP_FAULT;
            state     <= ST_IDLE;
          end else if (probeCnt == PC_W'(PROBES)) begin
            state <= ST_READ;
          end else begin
            probeCnt <= probeCnt + 1'b1;
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          if (!atChunkBottom) begin
            state <= ST_READ;
          end else if (remIsZero) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (irq) begin
            intr  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state    <= ST_PROBE;
            probeCnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_blk_copy.sv
module desc_blk_copy
  import blkcopy_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          HALF_W     = 16,
  parameter int          DATA_W     = 16,
  parameter int          CNT_W      = 16,
  parameter int          TAG_W      = 16,
  parameter int          CHUNK_LOG2 = 4,
  parameter logic [15:0] SMALL_TAG  = 16'h000E,
  parameter int          MAX_COUNT  = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [HALF_W-1:0] srcHi,
  input  logic [HALF_W-1:0] srcLo,
  input  logic [HALF_W-1:0] dstHi,
  input  logic [HALF_W-1:0] dstLo,
  input  logic [TAG_W-1:0]  cntTag,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              irq,
  output logic              busy,
  output logic              done,
  output logic              intr,
  output logic              trapValid,
  output logic [1:0]        trapCode,
  output logic [CNT_W-1:0]  remIdx,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memFault
);

  ctlStrobe_t strobe;
  logic       atChunkBottom;
  logic       remIsZero;

  blkcopy_ctl #(
    .CNT_W(CNT_W), .TAG_W(TAG_W), .SMALL_TAG(SMALL_TAG), .MAX_COUNT(MAX_COUNT)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .cntTag(cntTag), .cntVal(cntVal),
    .irq(irq), .memFault(memFault), .atChunkBottom(atChunkBottom),
    .remIsZero(remIsZero), .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .busy(busy), .done(done), .intr(intr), .trapValid(trapValid),
    .trapCode(trapCode)
  );

  blkcopy_dp #(
    .ADDR_W(ADDR_W), .HALF_W(HALF_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CHUNK_LOG2(CHUNK_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcHi(srcHi), .srcLo(srcLo),
    .dstHi(dstHi), .dstLo(dstLo), .cntVal(cntVal), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .remIdx(remIdx),
    .atChunkBottom(atChunkBottom), .remIsZero(remIsZero)
  );

endmodule

// File: rtl/desc_blk_copy_checker.sv
module desc_blk_copy_checker #(
  parameter int          CNT_W      = 16,
  parameter int          TAG_W      = 16,
  parameter int          CHUNK_LOG2 = 4,
  parameter logic [15:0] SMALL_TAG  = 16'h000E,
  parameter int          MAX_COUNT  = 32768
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [TAG_W-1:0] cntTag,
  input logic [CNT_W-1:0] cntVal,
  input logic             busy,
  input logic             done,
  input logic             intr,
  input logic             trapValid,
  input logic [1:0]       trapCode,
  input logic [CNT_W-1:0] remIdx,
  input logic             memReq,
  input logic             memWe
);

  logic tagOk;
  logic newReq;
  assign tagOk  = (cntTag == SMALL_TAG[TAG_W-1:0]);
  assign newReq = start && !busy;

  AST_WRITE_IS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (remIdx == $past(remIdx) - 1'b1)); // R8
  AST_DONE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remIdx == '1)); // R8
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (newReq && tagOk && cntVal == '0) |=> (done && !memReq && remIdx == '1)); // R5
  AST_TAG_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (newReq && !tagOk) |=> (trapValid && trapCode == 2'd1 && !memReq)); // R6
  AST_RANGE_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (newReq && tagOk && cntVal > CNT_W'(MAX_COUNT)) |=> (trapValid && trapCode == 2'd2 && !memReq)); // R7
  AST_INTR_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    intr |-> (remIdx[CHUNK_LOG2-1:0] == '1)); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, intr, trapValid})); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R10

endmodule

bind desc_blk_copy desc_blk_copy_checker #(
  .CNT_W(CNT_W), .TAG_W(TAG_W), .CHUNK_LOG2(CHUNK_LOG2),
  .SMALL_TAG(SMALL_TAG), .MAX_COUNT(MAX_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .cntTag(cntTag), .cntVal(cntVal),
  .busy(busy), .done(done), .intr(intr), .trapValid(trapValid),
  .trapCode(trapCode), .remIdx(remIdx), .memReq(memReq), .memWe(memWe)
);

// File: tb/desc_blk_copy_tb.sv
module desc_blk_copy_tb;

  localparam logic [15:0] TAG = 16'h000E;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [15:0] data;
  } op_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] srcHi = '0, srcLo = '0, dstHi = '0, dstLo = '0;
  logic [15:0] cntTag = '0, cntVal = '0;
  logic        irq = 1'b0;
  logic        busy, done, intr, trapValid;
  logic [1:0]  trapCode;
  logic [15:0] remIdx;
  logic        memReq, memWe;
  logic [31:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic        memFault = 1'b0;
  logic        faultEn = 1'b0;
  logic [31:0] faultAddr = '0;

  op_t expQ[$];
  op_t expOp;
  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  desc_blk_copy u_dut (
    .clk(clk), .rstN(rstN), .start(start), .srcHi(srcHi), .srcLo(srcLo),
    .dstHi(dstHi), .dstLo(dstLo), .cntTag(cntTag), .cntVal(cntVal), .irq(irq),
    .busy(busy), .done(done), .intr(intr), .trapValid(trapValid),
    .trapCode(trapCode), .remIdx(remIdx), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memFault(memFault)
  );

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C5A;
  endfunction

  // memory model: one-cycle read latency, fault flag alongside the data
  always @(posedge clk) begin
    memRdata <= (memReq && !memWe) ? pat(memAddr) : 16'h0000;
    memFault <= memReq && !memWe && faultEn && (memAddr == faultAddr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: every request is compared with the next predicted one
  always @(negedge clk) begin
    if (rstN && memReq && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected request addr", memAddr, 0);
      end else begin
        expOp = expQ.pop_front();
        check(memWe == expOp.we, "R3", "request kind", memWe, expOp.we);
        check(memAddr == expOp.addr, "R2", "request address", memAddr, expOp.addr);
        if (expOp.we)
          check(memWdata == expOp.data, "R1", "write data", memWdata, expOp.data);
      end
    end
  end

  // driver side: predict the requests of one chunk
  task automatic pushChunk(input logic [31:0] src, input logic [31:0] dst,
                           input int hi, input int faultStep);
    int lo = hi & ~15;
    logic [31:0] probe[4];
    probe[0] = src + 32'(hi);
    probe[1] = src + 32'(lo);
    probe[2] = dst + 32'(hi);
    probe[3] = dst + 32'(lo);
    for (int k = 0; k < 4; k++) begin
      expQ.push_back('{we: 1'b0, addr: probe[k], data: 16'h0});
      if (k == faultStep) return;
    end
    for (int i = hi; i >= lo; i--) begin
      expQ.push_back('{we: 1'b0, addr: src + 32'(i), data: 16'h0});
      expQ.push_back('{we: 1'b1, addr: dst + 32'(i), data: pat(src + 32'(i))});
    end
  endtask

  task automatic pushCopy(input logic [31:0] src, input logic [31:0] dst,
                          input int hi, input int chunks);
    int h = hi;
    for (int c = 0; c < chunks && h >= 0; c++) begin
      pushChunk(src, dst, h, -1);
      h = (h & ~15) - 1;
    end
  endtask

  task automatic launch(input logic [31:0] src, input logic [31:0] dst,
                        input logic [15:0] tag, input logic [15:0] cnt);
    @(negedge clk);
    {srcHi, srcLo} = src;
    {dstHi, dstLo} = dst;
    cntTag = tag;
    cntVal = cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // kind: 1 done, 2 intr, 3 trap, 0 timeout
  task automatic waitEnd(output int kind, output logic [1:0] code);
    kind = 0;
    code = 2'd0;
    for (int n = 0; n < 4000; n++) begin
      if (done) begin kind = 1; break; end
      if (intr) begin kind = 2; break; end
      if (trapValid) begin kind = 3; code = trapCode; break; end
      @(negedge clk);
    end
  endtask

  task automatic finishRun(input string req, input int expKind,
                           input logic [1:0] expCode, input logic [15:0] expRem);
    int kind;
    logic [1:0] code;
    waitEnd(kind, code);
    check(kind == expKind, req, "ending kind", kind, expKind);
    if (expKind == 3) check(code == expCode, req, "trap code", code, expCode);
    check(remIdx == expRem, req, "remaining index", remIdx, expRem);
    check(expQ.size() == 0, req, "requests left unissued", expQ.size(), 0);
    @(negedge clk);
    check(!done && !intr && !trapValid, "R10", "pulse width", {done, intr, trapValid}, 0);
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state, R8
    check(!busy && !memReq && !done && !intr && !trapValid, "R10", "reset outputs",
          {busy, memReq, done, intr, trapValid}, 0);
    check(remIdx == 16'hFFFF, "R8", "reset index", remIdx, 16'hFFFF);

    // R1 R2 R3: short single chunk
    pushCopy(32'h0000_1000, 32'h0000_2000, 4, 99);
    launch(32'h0000_1000, 32'h0000_2000, TAG, 16'd5);
    finishRun("R1", 1, 2'd0, 16'hFFFF);

    // R2: exact chunk of sixteen
    pushCopy(32'h0003_0100, 32'h0004_0200, 15, 99);
    launch(32'h0003_0100, 32'h0004_0200, TAG, 16'd16);
    finishRun("R2", 1, 2'd0, 16'hFFFF);

    // R2 R10: three chunks (5,16,16), with a start pulse while busy
    pushCopy(32'h0000_4000, 32'h0000_8000, 36, 99);
    launch(32'h0000_4000, 32'h0000_8000, TAG, 16'd37);
    repeat (6) @(negedge clk);
    cntVal = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finishRun("R10", 1, 2'd0, 16'hFFFF);

    // R11: carry from low half into high half
    pushCopy(32'h0001_FFFA, 32'h0005_FFFC, 9, 99);
    launch(32'h0001_FFFA, 32'h0005_FFFC, TAG, 16'd10);
    finishRun("R11", 1, 2'd0, 16'hFFFF);

    // R5: zero count
    launch(32'h0000_1000, 32'h0000_2000, TAG, 16'd0);
    finishRun("R5", 1, 2'd0, 16'hFFFF);

    // R6: bad tag
    launch(32'h0000_1000, 32'h0000_2000, 16'h0007, 16'd8);
    finishRun("R6", 3, 2'd1, 16'hFFFF);

    // R7: too large
    launch(32'h0000_1000, 32'h0000_2000, TAG, 16'd40000);
    finishRun("R7", 3, 2'd2, 16'hFFFF);

    // R7 R9: exactly 32768 accepted, stopped by interrupt after first chunk
    irq = 1'b1;
    pushCopy(32'h0010_0000, 32'h0020_0000, 32767, 1);
    launch(32'h0010_0000, 32'h0020_0000, TAG, 16'd32768);
    finishRun("R7", 2, 2'd0, 16'd32751);

    // R9: interrupt after first chunk of 40, then resume
    pushCopy(32'h0000_3000, 32'h0000_6000, 39, 1);
    launch(32'h0000_3000, 32'h0000_6000, TAG, 16'd40);
    finishRun("R9", 2, 2'd0, 16'd31);
    irq = 1'b0;
    pushCopy(32'h0000_3000, 32'h0000_6000, 31, 99);
    launch(32'h0000_3000, 32'h0000_6000, TAG, 16'd32);
    finishRun("R9", 1, 2'd0, 16'hFFFF);

    // R9: interrupt during the only chunk has no effect
    irq = 1'b1;
    pushCopy(32'h0000_3100, 32'h0000_6100, 9, 99);
    launch(32'h0000_3100, 32'h0000_6100, TAG, 16'd10);
    finishRun("R9", 1, 2'd0, 16'hFFFF);
    irq = 1'b0;

    // R4: fault on destination top probe of the second chunk
    faultEn = 1'b1;
    faultAddr = 32'h0000_8000 + 32'd31;
    pushCopy(32'h0000_4000, 32'h0000_8000, 36, 1);
    pushChunk(32'h0000_4000, 32'h0000_8000, 31, 2);
    launch(32'h0000_4000, 32'h0000_8000, TAG, 16'd37);
    finishRun("R4", 3, 2'd3, 16'd31);

    // R4: fault on source bottom probe of the first chunk
    faultAddr = 32'h0000_1000;
    pushChunk(32'h0000_1000, 32'h0000_2000, 4, 1);
    launch(32'h0000_1000, 32'h0000_2000, TAG, 16'd5);
    finishRun("R4", 3, 2'd3, 16'd4);
    faultEn = 1'b0;

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule